// File: doc/BRIEF.md
# Scannable m-of-n hysteresis threshold gate

This block is a threshold gate with hysteresis of the kind used to build null-convention asynchronous logic. It has N data inputs. The output rises as soon as at least M of them are high. Once high, it stays high while any input remains high, and it falls only when every input has returned low. The remembered output value lives in a single hold register. In functional mode that register simply follows the gate output. In test mode it becomes one stage of a scan chain, so a tester can either load the held state or read it out.

The held-state term of the output is always taken from the hold register. The output is therefore `(count >= M) | (any input high & held)`. In functional mode the register captures the output on every clock edge, which gives sampled hysteresis when inputs change once per clock.

In test mode, the scan-enable pin picks the action at each edge:
- low: the register captures the gate output;
- high: the register shifts in the scan input.

The register contents are always visible on the scan output. When M is 1, the gate is a plain OR of its inputs and has no hold register; the scan input is passed straight through to the scan output. A threshold of 0, or a threshold above N, stops elaboration with an error.

Top module: `thgate_scan`

## Requirements
- R1: Whenever at least M of the N data inputs are 1, `z` is 1 in the same cycle, whatever the held state.
- R2: Whenever all data inputs are 0, `z` is 0 in the same cycle, whatever the held state.
- R3: While between 1 and M-1 inputs are 1, `z` equals the held state. After a clock edge where the register captured, that held state is the value `z` had just before the edge.
- R4: With `test_en`=0, the register captures `z` on every rising edge of `clk`, and `scan_en` and `scan_in` have no effect. `scan_out` shows the register.
- R5: With `test_en`=1 and `scan_en`=0, the register captures `z` on each rising edge, and `scan_out` shows the captured value.
- R6: With `test_en`=1 and `scan_en`=1, the register loads `scan_in` on each rising edge. `scan_out` shows the loaded value, and the loaded value feeds the held-state term of `z`.
- R7: While `rst_n` is 0, the register is 0. As a result `scan_out` is 0, and `z` is 1 only when at least M inputs are 1.
- R8: With M=1, `z` is the OR of the data inputs and `scan_out` equals `scan_in` combinationally, with no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test and hold-register clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of the hold register |
| test_en | input | 1 | 1 = test mode, 0 = functional mode |
| scan_en | input | 1 | In test mode: 1 = shift, 0 = capture |
| scan_in | input | 1 | Scan chain input |
| data_in | input | N | Gate data inputs (1 = asserted) |
| z | output | 1 | Threshold gate output |
| scan_out | output | 1 | Scan chain output (hold register, or `scan_in` when M=1) |

## Verification
The bench walks the gate through the patterns below:
- a rise at exactly M inputs and a partial drop to M-1 inputs, which must hold the output high;
- a full drop to zero inputs, which must clear it;
- a rise from zero to fewer than M inputs, which must keep the output low.

A design that resets on a partial drop, or sets below threshold, shows up as a wrong `z` in those cycles. The bench shifts a 1 into the register while only some inputs are high, and expects `z` to follow the loaded value; a design that feeds back the live output instead of the register contents fails there. It also toggles `scan_en` and `scan_in` in functional mode, and a design that lets them corrupt the held state shows a mismatch on `scan_out`. A second, M=1 instance checks the pass-through scan path and the plain OR behaviour.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef enum logic [1:0] {
    HOLD_TRACK   = 2'd0,
    HOLD_CAPTURE = 2'd1,
    HOLD_SHIFT   = 2'd2
  } hold_op_e;

  function automatic hold_op_e decode_op(input logic test_en, input logic scan_en);
    if (!test_en)     return HOLD_TRACK;
    else if (scan_en) return HOLD_SHIFT;
    else              return HOLD_CAPTURE;
  endfunction

endpackage

// File: rtl/tg_popcount.sv
module tg_popcount #(
  parameter int N  = 3,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits_in,
  output logic [CW-1:0] count
);
  logic [CW-1:0] acc [N+1];

  assign acc[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_acc
    assign acc[i+1] = acc[i] + CW'(bits_in[i]);
  end

  assign count = acc[N];
endmodule

// File: rtl/tg_hold_cell.sv
module tg_hold_cell
  import tg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  hold_op_e op,
  input  logic     gate_val,
  input  logic     shift_val,
  output logic     held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
    end else begin
      unique case (op)
        HOLD_SHIFT: held <= shift_val;
        default:    held <= gate_val;
      endcase
    end
  end
endmodule

// File: rtl/thgate_scan.sv
module thgate_scan
  import tg_pkg::*;
#(
  parameter int M = 2,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_en,
  input  logic         scan_en,
  input  logic         scan_in,
  input  logic [N-1:0] data_in,
  output logic         z,
  output logic         scan_out
);
  localparam int CW = $clog2(N + 1);

  if (M < 1 || M > N) begin : g_bad_param
    $error("thgate_scan: threshold M must satisfy 1 <= M <= N");
  end

  if (M == 1) begin : g_or
    logic unused_pins;
    assign unused_pins = &{1'b0, clk, rst_n, test_en, scan_en};
    assign z        = |data_in;
    assign scan_out = scan_in;
  end else begin : g_hyst
    logic [CW-1:0] ones;
    logic          set_hit;
    logic          any_hit;
    logic          held;
    hold_op_e      op;

    tg_popcount #(.N(N)) u_cnt (
      .bits_in (data_in),
      .count   (ones)
    );

    assign set_hit = (ones >= CW'(M));
    assign any_hit = |data_in;
    assign op      = decode_op(test_en, scan_en);
    assign z       = set_hit | (any_hit & held);

    tg_hold_cell u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .gate_val  (z),
      .shift_val (scan_in),
      .held      (held)
    );

    assign scan_out = held;
  end
endmodule

// File: rtl/tg_scan_chk.sv
module tg_scan_chk #(
  parameter int M = 2,
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         test_en,
  input logic         scan_en,
  input logic         scan_in,
  input logic [N-1:0] data_in,
  input logic         z,
  input logic         scan_out
);
  if (M == 1) begin : g_or_chk
    logic unused_mode;
    assign unused_mode = &{1'b0, test_en, scan_en};
    // R8
    or_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (z == (data_in != '0)) && (scan_out == scan_in));
  end else begin : g_hyst_chk
    // R1
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(data_in) >= M) |-> z);
    // R2
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_in == '0) |-> !z);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(test_en && scan_en) &&
       ($countones(data_in) > 0) && ($countones(data_in) < M)) |-> (z == $past(z)));
    // R4
    track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_en) |=> (scan_out == $past(z)));
    // R5
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && !scan_en) |=> (scan_out == $past(z)));
    // R6
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && scan_en) |=> (scan_out == $past(scan_in)));
  end
endmodule

bind thgate_scan tg_scan_chk #(.M(M), .N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .test_en  (test_en),
  .scan_en  (scan_en),
  .scan_in  (scan_in),
  .data_in  (data_in),
  .z        (z),
  .scan_out (scan_out)
);

// File: tb/sim_thgate_scan.sv
module sim_thgate_scan;
  localparam int CLK_PERIOD = 10;
  localparam int M0 = 2;
  localparam int N0 = 3;
  localparam int N1 = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic te = 1'b0, se = 1'b0, si = 1'b0, si1 = 1'b0;
  logic [N0-1:0] din = '0;
  logic [N1-1:0] din1 = '0;
  logic z0, so0, z1, so1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic mstate = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thgate_scan #(.M(M0), .N(N0)) u0 (
    .clk(clk), .rst_n(rst_n), .test_en(te), .scan_en(se), .scan_in(si),
    .data_in(din), .z(z0), .scan_out(so0));

  thgate_scan #(.M(1), .N(N1)) u1 (
    .clk(clk), .rst_n(rst_n), .test_en(te), .scan_en(se), .scan_in(si1),
    .data_in(din1), .z(z1), .scan_out(so1));

  function automatic logic exp_z(input logic [N0-1:0] d, input logic st);
    return ($countones(d) >= M0) || ((d != '0) && st);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one vector at the falling edge, check outputs, then advance the model at the rising edge.
  task automatic step(input logic [N0-1:0] d, input logic t, input logic s,
                      input logic sin, input string req);
    logic ez;
    @(negedge clk);
    din = d; te = t; se = s; si = sin;
    din1 = N1'($urandom); si1 = 1'($urandom);
    #1;
    ez = exp_z(d, mstate);
    check({req, " z"}, z0, ez);
    check({req, " scan_out"}, so0, mstate);
    check("R8 or", z1, (din1 != '0));
    check("R8 pass", so1, si1);
    @(posedge clk);
    if (rst_n) mstate = (t && s) ? sin : ez;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R7: reset state, partial and full input sets
    @(negedge clk);
    din = 3'b011; #1;
    check("R7 z during reset", z0, 1'b1);
    check("R7 scan_out during reset", so0, 1'b0);
    @(negedge clk);
    din = 3'b001; #1;
    check("R7 partial during reset", z0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    mstate = 1'b0;

    // R1 set at threshold, R3 hold on partial drop, R2 clear
    step(3'b000, 0, 0, 0, "R2 idle");
    step(3'b100, 0, 0, 0, "R3 below threshold stays low");
    step(3'b101, 0, 0, 0, "R1 set at M");
    step(3'b001, 0, 0, 0, "R3 hold after drop");
    step(3'b010, 0, 0, 0, "R3 hold other input");
    step(3'b000, 0, 0, 0, "R2 clear");
    step(3'b010, 0, 0, 0, "R3 stays low after clear");
    step(3'b111, 0, 0, 0, "R1 all high");
    // R4 scan pins ignored in functional mode
    step(3'b100, 0, 1, 0, "R4 scan ignored hold");
    step(3'b100, 0, 1, 0, "R4 scan ignored state");
    step(3'b000, 0, 1, 1, "R4 scan ignored clear");
    step(3'b001, 0, 1, 1, "R4 state tracks z");
    // R6 shift a 1 in while partially set
    step(3'b001, 1, 1, 1, "R6 shift in");
    step(3'b001, 1, 0, 0, "R6 loaded feeds hold");
    // R5 capture
    step(3'b001, 1, 0, 0, "R5 capture");
    step(3'b000, 1, 1, 0, "R6 shift zero");
    step(3'b010, 1, 0, 0, "R5 capture low");
    step(3'b110, 1, 1, 0, "R1 set over zero state");
    step(3'b100, 1, 0, 1, "R6 shifted zero clears hold");

    for (int i = 0; i < 3000; i++) begin
      step(N0'($urandom), ($urandom % 3) == 0, 1'($urandom), 1'($urandom), "R3 random");
    end
    finish_run();
  end
endmodule